// File: doc/BRIEF.md
# Dual-Mode Cartridge Bank Register Unit

This block sits on the CPU write path of a game cartridge and keeps the bank-switching state of a mapper with two personalities. Every accepted write carries a 16-bit address and one data byte. A control byte selects the active index and the mode, and sets two address-inversion flags. A data port then loads whichever bank register that index names. A separate two-bit outer bank register picks one of four 128 KiB regions for both program and pattern memory.

In conventional mode the data port fills eight plain bank registers, R0 to R7. Pattern entries R0-R5 are clipped to seven bits and program entries R6-R7 to four bits, so that they stay inside one 128 KiB region. In extended mode the data port drives its own set of windows: four 8 KiB program windows, each written with its bits in reversed order, and eight 1 KiB pattern windows. Each pattern bank is assembled by OR-ing the data byte, a three-bit pending value left by an earlier write, and one bit of the index. The address translation that follows, the interrupt counter and the memories sit outside this block.

Writes arrive on a valid/ready pair. `wr_ready` is held high at all times, so a write is accepted in every cycle where `wr_valid` is high. The block never applies back-pressure and needs no buffering. An accepted write shows on the outputs after the clock edge that accepts it.

Top module: `cart_bank_regs`

## Requirements
- R1: A write whose address ANDed with 0xE001 equals 0x8000 is a control write. This covers 0x8002 and its mirrors under mask 0xE003, and both spellings have the same effect.
- R2: In a control byte, bits 4:0 are the stored index, bit 5 is the mode (`ext_mode`, 1 = extended), bit 6 drives `prg_inv` and bit 7 drives `chr_inv`.
- R3: A data write (address AND 0xE001 equal to 0x8001) in conventional mode loads register R[index bits 2:0] with the data masked to 0x7F for R0-R5 and to 0x0F for R6-R7. It leaves every extended window untouched. R n sits at `conv_regs[8n+7:8n]`.
- R4: In extended mode, a data write with index 3 to 6 loads program window (6 - index), where window 0 is the lowest CPU slot. Bank bit 0 comes from data bit 5, bit 1 from bit 4, bit 2 from bit 3 and bit 3 from bit 2. Window w is `ext_prg[4w+3:4w]`.
- R5: In extended mode, a data write with an even index from 8 to 30 stores data bits 2:0 as the pending value and changes no window. The pending value stays until the next such write.
- R6: In extended mode, a data write with an odd index from 9 to 15 loads pattern window (index bits 2:1) with (data bits 7:1) OR (index bit 1) OR (pending value << 4). Window k is `ext_chr[7k+6:7k]`.
- R7: In extended mode, a data write with an odd index from 17 to 31 loads pattern window 4 + (index bits 3:2) with (data bits 7:1) OR (pending value << 4).
- R8: In extended mode, a data write with index 0, 1, 2 or 7 changes no register, and extended data writes never alter R0-R7.
- R9: A write whose address ANDed with 0x5003 equals 0x5002 sets `outer_bank[0]` from data bit 0, and one that equals 0x5003 sets `outer_bank[1]` from data bit 5. Other addresses leave the outer bank alone.
- R10: After reset, `outer_bank` is 3, the mode is conventional, both flags and the index are 0, and every bank register and the pending value are 0.
- R11: `wr_ready` is always 1, and an accepted write is visible on the outputs after the next rising clock edge.
- R12: A cycle with `wr_valid` low changes no output, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | CPU write present |
| wr_ready | output | 1 | Always 1; no back-pressure |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ext_mode | output | 1 | 1 = extended mode |
| prg_inv | output | 1 | Program inversion flag |
| chr_inv | output | 1 | Pattern inversion flag |
| outer_bank | output | 2 | 128 KiB outer region |
| conv_regs | output | 64 | R0-R7, 8 bits each, R0 lowest |
| ext_prg | output | 16 | Four 4-bit extended program banks |
| ext_chr | output | 56 | Eight 7-bit extended pattern banks |

## Verification
Directed sequences come first. A program write with a single data bit set shows that the bit reversal is right. A pending-value write followed by low-window and high-window pattern writes separates the index-bit OR, which only the low windows take, from the pending-value OR, which both take. Unused extended indices and outer-bank writes at mirrored and non-matching addresses are checked for having no side effects. A long random phase mixes control writes in both modes, data writes, outer writes and idle cycles carrying live-looking addresses. In every cycle the outputs are compared with a behavioural model, which catches mode-gating errors and writes that leak into the wrong register group.

// File: rtl/cbr_pkg.sv
`timescale 1ns/1ps
package cbr_pkg;
  localparam int CPU_AW      = 16;
  localparam int CPU_DW      = 8;
  localparam int IDX_W       = 5;
  localparam int NUM_PRG_WIN = 4;
  localparam int PRG_BANK_W  = 4;
  localparam int NUM_CHR_WIN = 8;
  localparam int CHR_BANK_W  = 7;
  localparam int PEND_W      = 3;
  localparam int OUTER_W     = 2;
  localparam int NUM_CONV    = 8;
  localparam int PRG_SLOT_W  = $clog2(NUM_PRG_WIN);
  localparam int CHR_SLOT_W  = $clog2(NUM_CHR_WIN);

  localparam logic [CPU_AW-1:0] CTL_MASK   = 16'hE001;
  localparam logic [CPU_AW-1:0] CTL_MATCH  = 16'h8000;
  localparam logic [CPU_AW-1:0] MODE_MASK  = 16'hE003;
  localparam logic [CPU_AW-1:0] MODE_MATCH = 16'h8002;
  localparam logic [CPU_AW-1:0] DAT_MATCH  = 16'h8001;
  localparam logic [CPU_AW-1:0] OUT_MASK   = 16'h5003;
  localparam logic [CPU_AW-1:0] OUT_LO     = 16'h5002;
  localparam logic [CPU_AW-1:0] OUT_HI     = 16'h5003;

  typedef enum logic [2:0] {
    XK_NONE,
    XK_PRG,
    XK_PEND,
    XK_CHR_LO,
    XK_CHR_HI
  } xkind_t;

  function automatic xkind_t classify(input logic [IDX_W-1:0] idx);
    xkind_t k;
    if (idx[4:3] == 2'b00) begin
      if (idx[2:0] >= 3'd3 && idx[2:0] <= 3'd6) k = XK_PRG;
      else                                      k = XK_NONE;
    end else if (!idx[0]) begin
      k = XK_PEND;
    end else if (!idx[4]) begin
      k = XK_CHR_LO;
    end else begin
      k = XK_CHR_HI;
    end
    return k;
  endfunction

  function automatic logic [PRG_BANK_W-1:0] flip4(input logic [PRG_BANK_W-1:0] v);
    return {v[0], v[1], v[2], v[3]};
  endfunction
endpackage

// File: rtl/cbr_addr_decode.sv
`timescale 1ns/1ps
module cbr_addr_decode
  import cbr_pkg::*;
(
  input  logic              wr_valid,
  input  logic [CPU_AW-1:0] wr_addr,
  output logic              sel_ctl,
  output logic              sel_dat,
  output logic              sel_out_lo,
  output logic              sel_out_hi
);
  logic hit_ctl, hit_mode;

  always_comb begin
    hit_ctl    = (wr_addr & CTL_MASK)  == CTL_MATCH;
    hit_mode   = (wr_addr & MODE_MASK) == MODE_MATCH;
    sel_ctl    = wr_valid && (hit_ctl || hit_mode);
    sel_dat    = wr_valid && ((wr_addr & CTL_MASK) == DAT_MATCH);
    sel_out_lo = wr_valid && ((wr_addr & OUT_MASK) == OUT_LO);
    sel_out_hi = wr_valid && ((wr_addr & OUT_MASK) == OUT_HI);
  end
endmodule

// File: rtl/cbr_conv_regs.sv
`timescale 1ns/1ps
module cbr_conv_regs
  import cbr_pkg::*;
#(
  parameter int REGION_KIB = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [2:0]                 sel,
  input  logic [CPU_DW-1:0]          data,
  output logic [NUM_CONV*CPU_DW-1:0] regs_flat
);
  localparam logic [CPU_DW-1:0] CHR_MASK = CPU_DW'((1 << $clog2(REGION_KIB)) - 1);
  localparam logic [CPU_DW-1:0] PRG_MASK = CPU_DW'((REGION_KIB / 8) - 1);

  for (genvar g = 0; g < NUM_CONV; g++) begin : g_reg
    localparam logic [CPU_DW-1:0] KEEP = (g >= 6) ? PRG_MASK : CHR_MASK;
    logic [CPU_DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            q <= '0;
      else if (wr_en && sel == 3'(g))        q <= data & KEEP;
    end
    assign regs_flat[g*CPU_DW +: CPU_DW] = q;
  end

  // R3
  conv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));
endmodule

// File: rtl/cbr_ext_windows.sv
`timescale 1ns/1ps
module cbr_ext_windows
  import cbr_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  idx,
  input  logic [CPU_DW-1:0]                 data,
  output logic [NUM_PRG_WIN*PRG_BANK_W-1:0] prg_flat,
  output logic [NUM_CHR_WIN*CHR_BANK_W-1:0] chr_flat
);
  xkind_t                kind;
  logic [PRG_SLOT_W-1:0] prg_slot;
  logic [CHR_SLOT_W-1:0] chr_slot;
  logic [CHR_BANK_W-1:0] chr_val;
  logic [PRG_BANK_W-1:0] prg_val;
  logic [PEND_W-1:0]     pend_q;
  logic                  idx_or;

  always_comb begin
    kind     = classify(idx);
    prg_slot = PRG_SLOT_W'(3'd6 - idx[2:0]);
    prg_val  = flip4(data[5:2]);
    if (kind == XK_CHR_LO) chr_slot = {1'b0, idx[2:1]};
    else                   chr_slot = {1'b1, idx[3:2]};
    idx_or   = (kind == XK_CHR_LO) ? idx[1] : 1'b0;
    chr_val  = data[7:1] | {pend_q, 4'b0000} | {{(CHR_BANK_W-1){1'b0}}, idx_or};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pend_q <= '0;
    else if (wr_en && kind == XK_PEND)   pend_q <= data[PEND_W-1:0];
  end

  for (genvar p = 0; p < NUM_PRG_WIN; p++) begin : g_prg
    logic [PRG_BANK_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                                  q <= '0;
      else if (wr_en && kind == XK_PRG && prg_slot == PRG_SLOT_W'(p)) q <= prg_val;
    end
    assign prg_flat[p*PRG_BANK_W +: PRG_BANK_W] = q;
  end

  for (genvar c = 0; c < NUM_CHR_WIN; c++) begin : g_chr
    logic [CHR_BANK_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (wr_en && (kind == XK_CHR_LO || kind == XK_CHR_HI) &&
               chr_slot == CHR_SLOT_W'(c)) q <= chr_val;
    end
    assign chr_flat[c*CHR_BANK_W +: CHR_BANK_W] = q;
  end

  // R4
  prg_spares_chr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == XK_PRG) |=> $stable(chr_flat));
  // R5
  pend_spares_windows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == XK_PEND) |=> ($stable(chr_flat) && $stable(prg_flat)));
  // R8
  unused_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || kind == XK_NONE) |=> ($stable(chr_flat) && $stable(prg_flat)));
  // R6
  chr_spares_prg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (kind == XK_CHR_LO || kind == XK_CHR_HI)) |=> $stable(prg_flat));
endmodule

// File: rtl/cart_bank_regs.sv
`timescale 1ns/1ps
module cart_bank_regs
  import cbr_pkg::*;
#(
  parameter int REGION_KIB = 128
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_valid,
  output logic                              wr_ready,
  input  logic [CPU_AW-1:0]                 wr_addr,
  input  logic [CPU_DW-1:0]                 wr_data,
  output logic                              ext_mode,
  output logic                              prg_inv,
  output logic                              chr_inv,
  output logic [OUTER_W-1:0]                outer_bank,
  output logic [NUM_CONV*CPU_DW-1:0]        conv_regs,
  output logic [NUM_PRG_WIN*PRG_BANK_W-1:0] ext_prg,
  output logic [NUM_CHR_WIN*CHR_BANK_W-1:0] ext_chr
);
  logic             sel_ctl, sel_dat, sel_out_lo, sel_out_hi;
  logic [IDX_W-1:0] idx_q;

  assign wr_ready = 1'b1;

  cbr_addr_decode u_dec (
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .sel_ctl    (sel_ctl),
    .sel_dat    (sel_dat),
    .sel_out_lo (sel_out_lo),
    .sel_out_hi (sel_out_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      ext_mode <= 1'b0;
      prg_inv  <= 1'b0;
      chr_inv  <= 1'b0;
    end else if (sel_ctl) begin
      idx_q    <= wr_data[IDX_W-1:0];
      ext_mode <= wr_data[5];
      prg_inv  <= wr_data[6];
      chr_inv  <= wr_data[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outer_bank <= '1;
    end else begin
      if (sel_out_lo) outer_bank[0] <= wr_data[0];
      if (sel_out_hi) outer_bank[1] <= wr_data[5];
    end
  end

  cbr_conv_regs #(.REGION_KIB(REGION_KIB)) u_conv (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (sel_dat && !ext_mode),
    .sel       (idx_q[2:0]),
    .data      (wr_data),
    .regs_flat (conv_regs)
  );

  cbr_ext_windows u_ext (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (sel_dat && ext_mode),
    .idx      (idx_q),
    .data     (wr_data),
    .prg_flat (ext_prg),
    .chr_flat (ext_chr)
  );

  // R1
  decode_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_ctl, sel_dat, sel_out_lo, sel_out_hi}));
  // R2
  mode_from_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ctl |=> (ext_mode == $past(wr_data[5]) && chr_inv == $past(wr_data[7])));
  // R9
  outer_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_out_hi |=> (outer_bank[1] == $past(wr_data[5])));
  // R8
  ext_spares_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_dat && ext_mode) |=> $stable(conv_regs));
  // R12
  idle_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable({ext_mode, prg_inv, chr_inv, outer_bank, conv_regs, ext_prg, ext_chr}));
endmodule

// File: tb/cart_bank_regs_bench.sv
`timescale 1ns/1ps
module cart_bank_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        ext_mode, prg_inv, chr_inv;
  logic [1:0]  outer_bank;
  logic [63:0] conv_regs;
  logic [15:0] ext_prg;
  logic [55:0] ext_chr;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string phase = "reset";

  int m_idx, m_mode, m_pinv, m_cinv, m_outer, m_pend;
  int m_conv[8];
  int m_prg[4];
  int m_chr[8];

  always #10 clk = ~clk;

  cart_bank_regs u_cart_bank_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .ext_mode(ext_mode),
    .prg_inv(prg_inv), .chr_inv(chr_inv), .outer_bank(outer_bank),
    .conv_regs(conv_regs), .ext_prg(ext_prg), .ext_chr(ext_chr)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s [%s] actual=0x%0h expected=0x%0h", req, phase, got, exp);
    end
  endtask

  // behavioural reference, updated on the same edge as the design
  always @(posedge clk) begin
    int a, d, n, rv;
    if (!rst_n) begin
      m_idx = 0; m_mode = 0; m_pinv = 0; m_cinv = 0; m_outer = 3; m_pend = 0;
      for (int i = 0; i < 8; i++) begin m_conv[i] = 0; m_chr[i] = 0; end
      for (int i = 0; i < 4; i++) m_prg[i] = 0;
    end else if (wr_valid) begin
      a = int'(wr_addr); d = int'(wr_data);
      if ((a & 'hE001) == 'h8000) begin
        m_idx = d % 32; m_mode = (d >> 5) & 1; m_pinv = (d >> 6) & 1; m_cinv = d >> 7;
      end else if ((a & 'hE001) == 'h8001) begin
        if (m_mode == 0) begin
          n = m_idx % 8;
          m_conv[n] = d & ((n >= 6) ? 15 : 127);
        end else if (m_idx >= 3 && m_idx <= 6) begin
          rv = ((d >> 5) & 1) | (((d >> 4) & 1) << 1) | (((d >> 3) & 1) << 2) | (((d >> 2) & 1) << 3);
          m_prg[6 - m_idx] = rv;
        end else if (m_idx >= 8 && (m_idx % 2) == 0) begin
          m_pend = d % 8;
        end else if (m_idx >= 9 && m_idx <= 15) begin
          m_chr[(m_idx >> 1) % 4] = (d >> 1) | ((m_idx >> 1) & 1) | (m_pend << 4);
        end else if (m_idx >= 17) begin
          m_chr[4 + ((m_idx >> 2) % 4)] = (d >> 1) | (m_pend << 4);
        end
      end else if ((a & 'h5003) == 'h5002) begin
        m_outer = (m_outer & 2) | (d & 1);
      end else if ((a & 'h5003) == 'h5003) begin
        m_outer = (m_outer & 1) | (((d >> 5) & 1) << 1);
      end
    end
  end

  // full comparison away from the active edge, every cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R11", int'(wr_ready), 1);
      chk("R2", int'(ext_mode), m_mode);
      chk("R2", int'(prg_inv), m_pinv);
      chk("R2", int'(chr_inv), m_cinv);
      chk("R9", int'(outer_bank), m_outer);
      for (int i = 0; i < 8; i++) chk("R3", int'(conv_regs[i*8 +: 8]), m_conv[i]);
      for (int i = 0; i < 4; i++) chk("R4", int'(ext_prg[i*4 +: 4]), m_prg[i]);
      for (int i = 0; i < 4; i++) chk("R6", int'(ext_chr[i*7 +: 7]), m_chr[i]);
      for (int i = 4; i < 8; i++) chk("R7", int'(ext_chr[i*7 +: 7]), m_chr[i]);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0; wr_addr = 16'h0000; wr_data = 8'h00;
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    #1;
    // R10 reset values
    phase = "R10";
    chk("R10", int'(outer_bank), 3);
    chk("R10", int'(ext_mode), 0);
    chk("R10", int'(conv_regs), 0);
    chk("R10", int'(ext_prg), 0);
    chk("R10", int'(ext_chr), 0);
    rst_n = 1'b1;

    // R4 bit reversal: data bit 2 lands on bank bit 3
    phase = "R4 reverse";
    wr(16'h8000, 8'h23);
    wr(16'h8001, 8'h04);
    chk("R4", int'(ext_prg[12 +: 4]), 8);
    // R1 control via 0x8002 spelling, window 0 from index 6
    phase = "R1 alt control";
    wr(16'h8002, 8'h26);
    chk("R1", int'(ext_mode), 1);
    wr(16'h8001, 8'h20);
    chk("R4", int'(ext_prg[0 +: 4]), 1);

    // R5 pending value, then R6 low window with index bit OR
    phase = "R5 pending";
    wr(16'h8000, 8'h28);
    wr(16'h8001, 8'h05);
    chk("R5", int'(ext_chr), 0);
    wr(16'h8000, 8'h2B);
    wr(16'h8001, 8'h10);
    chk("R6", int'(ext_chr[7 +: 7]), 'h59);
    // R7 high window, pending value persists, no index OR
    phase = "R7 high";
    wr(16'hA000 & 16'h8000, 8'h3D);
    wr(16'h8001, 8'h02);
    chk("R7", int'(ext_chr[49 +: 7]), 'h51);
    chk("R5", int'(ext_chr[7 +: 7]), 'h59);

    // R8 unused extended index changes nothing
    phase = "R8 unused";
    wr(16'h8000, 8'h21);
    wr(16'h8001, 8'hFF);
    chk("R8", int'(ext_prg[12 +: 4]), 8);
    chk("R8", int'(conv_regs[8 +: 8]), 0);
    chk("R8", int'(ext_chr[49 +: 7]), 'h51);

    // R3 conventional masks and flags
    phase = "R3 conv";
    wr(16'h8000, 8'hC6);
    chk("R2", int'({chr_inv, prg_inv, ext_mode}), 6);
    wr(16'h8001, 8'hFF);
    chk("R3", int'(conv_regs[48 +: 8]), 'h0F);
    wr(16'h8000, 8'h01);
    wr(16'h9FFF & 16'h8001 | 16'h1000, 8'hFF);
    chk("R3", int'(conv_regs[8 +: 8]), 'h7F);
    chk("R3", int'(ext_prg[12 +: 4]), 8);

    // R9 outer register, mirror and non-matching address
    phase = "R9 outer";
    wr(16'h5002, 8'hFE);
    chk("R9", int'(outer_bank), 2);
    wr(16'h5003, 8'hDF);
    chk("R9", int'(outer_bank), 0);
    wr(16'hD003, 8'h20);
    chk("R9", int'(outer_bank), 2);
    wr(16'h5000, 8'hFF);
    chk("R9", int'(outer_bank), 2);

    // R12 idle cycle with a live-looking address
    phase = "R12 idle";
    @(negedge clk);
    wr_valid = 1'b0; wr_addr = 16'h5002; wr_data = 8'hFF;
    @(negedge clk);
    #1;
    chk("R12", int'(outer_bank), 2);
    wr_addr = 16'h0000; wr_data = 8'h00;

    // random mix compared every cycle against the model
    phase = "R11 random";
    for (int i = 0; i < 4000; i++) begin
      int sel;
      @(negedge clk);
      sel = $urandom_range(0, 9);
      wr_valid = ($urandom_range(0, 3) != 0);
      wr_data  = 8'($urandom);
      case (sel)
        0, 1: wr_addr = 16'h8000 | 16'($urandom_range(0, 1) * 2);
        2, 3, 4: wr_addr = 16'h8001;
        5: wr_addr = 16'h5002;
        6: wr_addr = 16'h5003;
        7: wr_addr = 16'hE001 & 16'($urandom) | 16'h8000;
        default: wr_addr = 16'($urandom);
      endcase
    end
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule